// File: doc/BRIEF.md
# Register-Reference Instruction Execution Unit

This block decodes and carries out the register-reference class of instructions of a small accumulator machine with 16-bit instruction words. It owns the accumulator, a one-bit carry flag, three index registers, a base register, the program counter and a sticky halt flag. Memory-reference and input/output instructions, memory and the address path belong to other blocks. Instructions of those classes pass through this block as plain program-counter advances.

Operation alternates between two phases. In the fetch phase the block raises `instr_ready` and latches the next word offered with `instr_valid`. In the following execute phase it applies the selected micro-operation to its registers. It also decides whether the next instruction is skipped, in which case the program counter advances by two instead of one. The operations are: clear and complement of the accumulator and the carry, rotation through the carry, increment, four conditional skips, halt, exchanges between the accumulator and the index or base registers, and increment- or decrement-and-skip-if-zero on the index registers. The accumulator and the carry/index/base registers are visible on observation outputs.

Top module: `rri_exec_unit`

## Requirements
- R1: After reset the accumulator, carry, all three index registers, the base register and the program counter are zero, `halted_o` is 0 and `instr_ready` is 1.
- R2: A word accepted at a clock edge (`instr_valid` and `instr_ready` both high) is executed in the next cycle. During that cycle `exec_done_o` is 1 and `instr_ready` is 0. Register results are visible on the outputs after the following edge, and `exec_done_o` lasts exactly one cycle.
- R3: Only words whose bits 15:12 equal 4'b0111 are register-reference instructions. Any other op code leaves all registers unchanged, raises neither `skip_o` nor `illegal_o`, and advances the program counter by one.
- R4: With op code 0111, control field 12'h800 clears the accumulator, 12'h400 clears the carry, 12'h200 inverts every accumulator bit, and 12'h100 inverts the carry.
- R5: Field 12'h080 rotates right through the carry: bit 0 goes to the carry and the old carry enters bit 15. Field 12'h040 rotates left through the carry: bit 15 goes to the carry and the old carry enters bit 0.
- R6: Field 12'h020 adds one to the accumulator modulo 2^16 and leaves the carry unchanged.
- R7: Fields 12'h010, 12'h008, 12'h004 and 12'h002 skip under four conditions. 12'h010 skips when the accumulator is positive, meaning bit 15 is 0 and the value is nonzero. 12'h008 skips when bit 15 is 1. 12'h004 skips when the accumulator is zero. 12'h002 skips when the carry is 0.
- R8: `skip_o` is 1 only in an execute cycle whose instruction skips. The program counter advances by 2 after such a cycle and by 1 after every other execute cycle, and it does not change outside execute cycles.
- R9: Field 12'h001 sets `halted_o`. It stays set until reset, holds `instr_ready` at 0, and no further word is accepted.
- R10: Fields 12'h801, 12'h802, 12'h803 and 12'h804 swap the accumulator with index register 1, 2 or 3, or with the base register, in a single execute cycle.
- R11: Fields 12'h805, 12'h806 and 12'h807 increment index register 1, 2 or 3. Field 12'h808 decrements index register 1. Each of these skips when the new value is zero.
- R12: With op code 0111, any other field (zero, more than one of bits 10:0 set, or bit 11 with code 9 to 15) executes as a no-op. It raises `illegal_o` for its one execute cycle, never skips, and advances the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word |
| instr_ready | output | 1 | Fetch phase and not halted |
| exec_done_o | output | 1 | Execute cycle in progress |
| skip_o | output | 1 | Current instruction skips the next one |
| illegal_o | output | 1 | Unrecognised register-reference field |
| halted_o | output | 1 | Sticky halt state |
| pc_o | output | PC_W (12) | Program counter |
| acc_o | output | DATA_W (16) | Accumulator |
| carry_o | output | 1 | Carry flag |
| ix1_o | output | DATA_W (16) | Index register 1 |
| ix2_o | output | DATA_W (16) | Index register 2 |
| ix3_o | output | DATA_W (16) | Index register 3 |
| base_o | output | DATA_W (16) | Base register |

## Verification
The bench runs the positive-skip test on a zero accumulator. A design that tests only the sign bit would skip there and leave the program counter one word ahead. It rotates words whose shifted-out bit differs from the old carry, which exposes a rotate that drops the carry or feeds it into the wrong end. It wraps index registers across zero both upward and downward, catching a skip keyed to the old value rather than the new one. It also drives malformed fields that share bit 11 with the exchange codes, or set two one-hot bits, which a loose decoder would execute as a real operation. Finally it keeps offering words after a halt, to catch a design that resumes fetching.

// File: rtl/rri_pkg.sv
package rri_pkg;

   localparam int INSTR_W = 16;
   localparam int OPC_W   = 4;
   localparam int FLD_W   = 12;
   localparam int NUM_IX  = 3;

   typedef enum logic [4:0] {
      OP_NOP,
      OP_BAD,
      OP_CLR_ACC,
      OP_CLR_CARRY,
      OP_CPL_ACC,
      OP_CPL_CARRY,
      OP_ROT_RIGHT,
      OP_ROT_LEFT,
      OP_INC_ACC,
      OP_SKIP_POS,
      OP_SKIP_NEG,
      OP_SKIP_ZERO,
      OP_SKIP_CZERO,
      OP_HALT,
      OP_XCHG_IX1,
      OP_XCHG_IX2,
      OP_XCHG_IX3,
      OP_XCHG_BASE,
      OP_INCSKIP_IX1,
      OP_INCSKIP_IX2,
      OP_INCSKIP_IX3,
      OP_DECSKIP_IX1
   } rr_op_e;

   typedef enum logic {
      PH_FETCH,
      PH_EXEC
   } phase_e;

endpackage

// File: rtl/rri_decode.sv
module rri_decode
   import rri_pkg::*;
#(
   parameter logic [OPC_W-1:0] RR_OPCODE = 4'b0111
) (
   input  logic [INSTR_W-1:0] ir,
   output rr_op_e             op
);

   logic [OPC_W-1:0] opc;
   logic [FLD_W-1:0] fld;

   assign opc = ir[INSTR_W-1 -: OPC_W];
   assign fld = ir[FLD_W-1:0];

   always_comb begin
      if (opc != RR_OPCODE) begin
         op = OP_NOP;
      end else begin
         case (fld)
            12'h800: op = OP_CLR_ACC;
            12'h400: op = OP_CLR_CARRY;
            12'h200: op = OP_CPL_ACC;
            12'h100: op = OP_CPL_CARRY;
            12'h080: op = OP_ROT_RIGHT;
            12'h040: op = OP_ROT_LEFT;
            12'h020: op = OP_INC_ACC;
            12'h010: op = OP_SKIP_POS;
            12'h008: op = OP_SKIP_NEG;
            12'h004: op = OP_SKIP_ZERO;
            12'h002: op = OP_SKIP_CZERO;
            12'h001: op = OP_HALT;
            12'h801: op = OP_XCHG_IX1;
            12'h802: op = OP_XCHG_IX2;
            12'h803: op = OP_XCHG_IX3;
            12'h804: op = OP_XCHG_BASE;
            12'h805: op = OP_INCSKIP_IX1;
            12'h806: op = OP_INCSKIP_IX2;
            12'h807: op = OP_INCSKIP_IX3;
            12'h808: op = OP_DECSKIP_IX1;
            default: op = OP_BAD;
         endcase
      end
   end

endmodule

// File: rtl/rri_datapath.sv
module rri_datapath
   import rri_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  rr_op_e            op,
   input  logic [DATA_W-1:0] acc,
   input  logic              carry,
   input  logic [DATA_W-1:0] ix     [NUM_IX],
   input  logic [DATA_W-1:0] base,
   output logic [DATA_W-1:0] nxt_acc,
   output logic              nxt_carry,
   output logic [DATA_W-1:0] nxt_ix [NUM_IX],
   output logic [DATA_W-1:0] nxt_base,
   output logic              skip,
   output logic              halt_req
);

   localparam int                MSB    = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE_D  = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] ZERO_D = '0;

   logic acc_zero;
   logic acc_neg;
   logic [DATA_W-1:0] ix_up [NUM_IX];
   logic [DATA_W-1:0] ix1_dn;

   assign acc_zero = (acc == ZERO_D);
   assign acc_neg  = acc[MSB];
   assign ix1_dn   = ix[0] - ONE_D;

   for (genvar g = 0; g < NUM_IX; g++) begin : g_ix_up
      assign ix_up[g] = ix[g] + ONE_D;
   end

   always_comb begin
      nxt_acc   = acc;
      nxt_carry = carry;
      nxt_ix    = ix;
      nxt_base  = base;
      skip      = 1'b0;
      halt_req  = 1'b0;
      case (op)
         OP_CLR_ACC:    nxt_acc = ZERO_D;
         OP_CLR_CARRY:  nxt_carry = 1'b0;
         OP_CPL_ACC:    nxt_acc = ~acc;
         OP_CPL_CARRY:  nxt_carry = ~carry;
         OP_ROT_RIGHT: begin
            nxt_acc   = {carry, acc[MSB:1]};
            nxt_carry = acc[0];
         end
         OP_ROT_LEFT: begin
            nxt_acc   = {acc[MSB-1:0], carry};
            nxt_carry = acc[MSB];
         end
         OP_INC_ACC:    nxt_acc = acc + ONE_D;
         OP_SKIP_POS:   skip = !acc_neg && !acc_zero;
         OP_SKIP_NEG:   skip = acc_neg;
         OP_SKIP_ZERO:  skip = acc_zero;
         OP_SKIP_CZERO: skip = !carry;
         OP_HALT:       halt_req = 1'b1;
         OP_XCHG_IX1: begin
            nxt_acc   = ix[0];
            nxt_ix[0] = acc;
         end
         OP_XCHG_IX2: begin
            nxt_acc   = ix[1];
            nxt_ix[1] = acc;
         end
         OP_XCHG_IX3: begin
            nxt_acc   = ix[2];
            nxt_ix[2] = acc;
         end
         OP_XCHG_BASE: begin
            nxt_acc  = base;
            nxt_base = acc;
         end
         OP_INCSKIP_IX1: begin
            nxt_ix[0] = ix_up[0];
            skip      = (ix_up[0] == ZERO_D);
         end
         OP_INCSKIP_IX2: begin
            nxt_ix[1] = ix_up[1];
            skip      = (ix_up[1] == ZERO_D);
         end
         OP_INCSKIP_IX3: begin
            nxt_ix[2] = ix_up[2];
            skip      = (ix_up[2] == ZERO_D);
         end
         OP_DECSKIP_IX1: begin
            nxt_ix[0] = ix1_dn;
            skip      = (ix1_dn == ZERO_D);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rri_exec_unit.sv
module rri_exec_unit
   import rri_pkg::*;
#(
   parameter int               DATA_W    = 16,
   parameter int               PC_W      = 12,
   parameter logic [OPC_W-1:0] RR_OPCODE = 4'b0111
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   output logic               instr_ready,
   output logic               exec_done_o,
   output logic               skip_o,
   output logic               illegal_o,
   output logic               halted_o,
   output logic [PC_W-1:0]    pc_o,
   output logic [DATA_W-1:0]  acc_o,
   output logic               carry_o,
   output logic [DATA_W-1:0]  ix1_o,
   output logic [DATA_W-1:0]  ix2_o,
   output logic [DATA_W-1:0]  ix3_o,
   output logic [DATA_W-1:0]  base_o
);

   localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};
   localparam logic [PC_W-1:0] PC_TWO = {{(PC_W-2){1'b0}}, 2'b10};

   if (DATA_W < 2) begin : g_chk_data_w
      $error("rri_exec_unit: DATA_W must be at least 2");
   end
   if (PC_W < 2) begin : g_chk_pc_w
      $error("rri_exec_unit: PC_W must be at least 2");
   end

   phase_e              phase_q;
   logic [INSTR_W-1:0]  ir_q;
   logic [DATA_W-1:0]   acc_q;
   logic                carry_q;
   logic [DATA_W-1:0]   base_q;
   logic [DATA_W-1:0]   ix_q [NUM_IX];
   logic [PC_W-1:0]     pc_q;
   logic                halted_q;

   rr_op_e              op;
   logic [DATA_W-1:0]   nxt_acc;
   logic                nxt_carry;
   logic [DATA_W-1:0]   nxt_ix [NUM_IX];
   logic [DATA_W-1:0]   nxt_base;
   logic                dp_skip;
   logic                dp_halt;
   logic                in_exec;

   rri_decode #(.RR_OPCODE(RR_OPCODE)) u_dec (
      .ir (ir_q),
      .op (op)
   );

   rri_datapath #(.DATA_W(DATA_W)) u_dp (
      .op        (op),
      .acc       (acc_q),
      .carry     (carry_q),
      .ix        (ix_q),
      .base      (base_q),
      .nxt_acc   (nxt_acc),
      .nxt_carry (nxt_carry),
      .nxt_ix    (nxt_ix),
      .nxt_base  (nxt_base),
      .skip      (dp_skip),
      .halt_req  (dp_halt)
   );

   assign in_exec = (phase_q == PH_EXEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_FETCH;
         ir_q     <= '0;
         acc_q    <= '0;
         carry_q  <= 1'b0;
         base_q   <= '0;
         pc_q     <= '0;
         halted_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_FETCH: begin
               if (instr_valid && !halted_q) begin
                  ir_q    <= instr_word;
                  phase_q <= PH_EXEC;
               end
            end
            PH_EXEC: begin
               acc_q   <= nxt_acc;
               carry_q <= nxt_carry;
               base_q  <= nxt_base;
               pc_q    <= pc_q + (dp_skip ? PC_TWO : PC_ONE);
               if (dp_halt) begin
                  halted_q <= 1'b1;
               end
               phase_q <= PH_FETCH;
            end
            default: phase_q <= PH_FETCH;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_IX; g++) begin : g_ix_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ix_q[g] <= '0;
         end else if (in_exec) begin
            ix_q[g] <= nxt_ix[g];
         end
      end
   end

   assign instr_ready = !in_exec && !halted_q;
   assign exec_done_o = in_exec;
   assign skip_o      = in_exec && dp_skip;
   assign illegal_o   = in_exec && (op == OP_BAD);
   assign halted_o    = halted_q;
   assign pc_o        = pc_q;
   assign acc_o       = acc_q;
   assign carry_o     = carry_q;
   assign ix1_o       = ix_q[0];
   assign ix2_o       = ix_q[1];
   assign ix3_o       = ix_q[2];
   assign base_o      = base_q;

endmodule

// File: rtl/rri_exec_unit_chk.sv
module rri_exec_unit_chk #(
   parameter int DATA_W = 16,
   parameter int PC_W   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic              instr_ready,
   input logic              exec_done_o,
   input logic              skip_o,
   input logic              illegal_o,
   input logic              halted_o,
   input logic [PC_W-1:0]   pc_o,
   input logic [DATA_W-1:0] acc_o,
   input logic              carry_o
);

   localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};
   localparam logic [PC_W-1:0] PC_TWO = {{(PC_W-2){1'b0}}, 2'b10};

   logic [PC_W-1:0] pc_step;
   assign pc_step = skip_o ? PC_TWO : PC_ONE;

   p_accept_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready) |=> exec_done_o);

   p_exec_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exec_done_o |=> !exec_done_o);

   p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exec_done_o |-> !instr_ready);

   p_pc_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_done_o |=> (pc_o == $past(pc_o) + $past(pc_step)));

   p_pc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_done_o |=> $stable(pc_o));

   p_skip_in_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> exec_done_o);

   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o);

   p_halt_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> !instr_ready);

   p_illegal_keeps_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |=> ($stable(acc_o) && $stable(carry_o)));

   p_illegal_no_skip_r12: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !skip_o);

endmodule

bind rri_exec_unit rri_exec_unit_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_ready (instr_ready),
   .exec_done_o (exec_done_o),
   .skip_o      (skip_o),
   .illegal_o   (illegal_o),
   .halted_o    (halted_o),
   .pc_o        (pc_o),
   .acc_o       (acc_o),
   .carry_o     (carry_o)
);

// File: tb/rri_exec_unit_test.sv
module rri_exec_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W       = 12;
   localparam int DATA_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              instr_valid;
   logic [15:0]       instr_word;
   logic              instr_ready;
   logic              exec_done_o;
   logic              skip_o;
   logic              illegal_o;
   logic              halted_o;
   logic [PC_W-1:0]   pc_o;
   logic [DATA_W-1:0] acc_o;
   logic              carry_o;
   logic [DATA_W-1:0] ix1_o;
   logic [DATA_W-1:0] ix2_o;
   logic [DATA_W-1:0] ix3_o;
   logic [DATA_W-1:0] base_o;

   int n_chk = 0;
   int n_err = 0;
   int m_pc  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rri_exec_unit #(.DATA_W(DATA_W), .PC_W(PC_W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_word  (instr_word),
      .instr_ready (instr_ready),
      .exec_done_o (exec_done_o),
      .skip_o      (skip_o),
      .illegal_o   (illegal_o),
      .halted_o    (halted_o),
      .pc_o        (pc_o),
      .acc_o       (acc_o),
      .carry_o     (carry_o),
      .ix1_o       (ix1_o),
      .ix2_o       (ix2_o),
      .ix3_o       (ix3_o),
      .base_o      (base_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one instruction through fetch and execute; checks R2 handshake, skip, illegal, pc
   task automatic issue(input logic [15:0] w, input logic exp_sk,
                        input logic exp_il, input string req);
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = w;
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R2", "exec_done", exec_done_o, 1);
      chk("R2", "ready in exec", instr_ready, 0);
      chk(req, "skip", skip_o, exp_sk);
      chk(req, "illegal", illegal_o, exp_il);
      @(posedge clk);
      @(negedge clk);
      m_pc = (m_pc + 1 + int'(exp_sk)) % (1 << PC_W);
      chk("R8", "pc", pc_o, m_pc);
      chk("R2", "exec_done cleared", exec_done_o, 0);
   endtask

   task automatic t_reset_state();
      chk("R1", "acc", acc_o, 0);
      chk("R1", "carry", carry_o, 0);
      chk("R1", "ix1", ix1_o, 0);
      chk("R1", "ix2", ix2_o, 0);
      chk("R1", "ix3", ix3_o, 0);
      chk("R1", "base", base_o, 0);
      chk("R1", "pc", pc_o, 0);
      chk("R1", "halted", halted_o, 0);
      chk("R1", "ready", instr_ready, 1);
   endtask

   task automatic t_clear_cpl();
      issue(16'h7200, 0, 0, "R4"); chk("R4", "cpl acc", acc_o, 16'hFFFF);
      issue(16'h7100, 0, 0, "R4"); chk("R4", "cpl carry", carry_o, 1);
      issue(16'h7800, 0, 0, "R4"); chk("R4", "clr acc", acc_o, 0);
      chk("R4", "carry kept", carry_o, 1);
      issue(16'h7400, 0, 0, "R4"); chk("R4", "clr carry", carry_o, 0);
   endtask

   task automatic t_rotate();
      issue(16'h7200, 0, 0, "R5");
      issue(16'h7040, 0, 0, "R5");
      chk("R5", "rotl acc", acc_o, 16'hFFFE); chk("R5", "rotl carry", carry_o, 1);
      issue(16'h7080, 0, 0, "R5");
      chk("R5", "rotr acc", acc_o, 16'hFFFF); chk("R5", "rotr carry", carry_o, 0);
      issue(16'h7080, 0, 0, "R5");
      chk("R5", "rotr2 acc", acc_o, 16'h7FFF); chk("R5", "rotr2 carry", carry_o, 1);
   endtask

   task automatic t_increment();
      issue(16'h7020, 0, 0, "R6");
      chk("R6", "inc acc", acc_o, 16'h8000); chk("R6", "carry kept", carry_o, 1);
      issue(16'h7800, 0, 0, "R6");
      issue(16'h7200, 0, 0, "R6");
      issue(16'h7020, 0, 0, "R6");
      chk("R6", "inc wrap", acc_o, 0); chk("R6", "carry kept wrap", carry_o, 1);
   endtask

   task automatic t_skips();
      issue(16'h7004, 1, 0, "R7");
      issue(16'h7002, 0, 0, "R7");
      issue(16'h7010, 0, 0, "R7");
      issue(16'h7008, 0, 0, "R7");
      issue(16'h7020, 0, 0, "R7");
      issue(16'h7010, 1, 0, "R7");
      issue(16'h7008, 0, 0, "R7");
      issue(16'h7200, 0, 0, "R7");
      chk("R7", "acc", acc_o, 16'hFFFE);
      issue(16'h7008, 1, 0, "R7");
      issue(16'h7010, 0, 0, "R7");
      issue(16'h7400, 0, 0, "R7");
      issue(16'h7002, 1, 0, "R7");
      issue(16'h7004, 0, 0, "R7");
   endtask

   task automatic t_swaps();
      issue(16'h7800, 0, 0, "R10");
      issue(16'h7020, 0, 0, "R10");
      issue(16'h7801, 0, 0, "R10");
      chk("R10", "ix1", ix1_o, 1); chk("R10", "acc from ix1", acc_o, 0);
      issue(16'h7020, 0, 0, "R10");
      issue(16'h7020, 0, 0, "R10");
      issue(16'h7802, 0, 0, "R10");
      chk("R10", "ix2", ix2_o, 2); chk("R10", "acc from ix2", acc_o, 0);
      for (int i = 0; i < 3; i++) issue(16'h7020, 0, 0, "R10");
      issue(16'h7803, 0, 0, "R10");
      chk("R10", "ix3", ix3_o, 3); chk("R10", "acc from ix3", acc_o, 0);
      issue(16'h7200, 0, 0, "R10");
      issue(16'h7804, 0, 0, "R10");
      chk("R10", "base", base_o, 16'hFFFF); chk("R10", "acc from base", acc_o, 0);
      issue(16'h7801, 0, 0, "R10");
      chk("R10", "swap back acc", acc_o, 1); chk("R10", "swap back ix1", ix1_o, 0);
      chk("R10", "ix2 untouched", ix2_o, 2);
   endtask

   task automatic t_index_skip();
      issue(16'h7800, 0, 0, "R11");
      issue(16'h7200, 0, 0, "R11");
      issue(16'h7802, 0, 0, "R11");
      chk("R11", "ix2 preset", ix2_o, 16'hFFFF); chk("R11", "acc", acc_o, 2);
      issue(16'h7806, 1, 0, "R11"); chk("R11", "ix2 wrap", ix2_o, 0);
      issue(16'h7807, 0, 0, "R11"); chk("R11", "ix3 inc", ix3_o, 4);
      issue(16'h7805, 0, 0, "R11"); chk("R11", "ix1 inc", ix1_o, 1);
      issue(16'h7808, 1, 0, "R11"); chk("R11", "ix1 dec", ix1_o, 0);
      issue(16'h7808, 0, 0, "R11"); chk("R11", "ix1 dec wrap", ix1_o, 16'hFFFF);
      chk("R11", "acc untouched", acc_o, 2);
   endtask

   task automatic t_illegal();
      logic [15:0] bad [5] = '{16'h7000, 16'h7809, 16'h7300, 16'h7811, 16'h7C01};
      foreach (bad[i]) begin
         issue(bad[i], 0, 1, "R12");
         chk("R12", "acc kept", acc_o, 2);
         chk("R12", "carry kept", carry_o, 0);
         chk("R12", "ix1 kept", ix1_o, 16'hFFFF);
         chk("R12", "halted", halted_o, 0);
      end
   endtask

   task automatic t_other_class();
      issue(16'h3200, 0, 0, "R3"); chk("R3", "acc kept", acc_o, 2);
      issue(16'hF800, 0, 0, "R3"); chk("R3", "acc kept", acc_o, 2);
      issue(16'h6001, 0, 0, "R3"); chk("R3", "not halted", halted_o, 0);
      issue(16'h6806, 0, 0, "R3"); chk("R3", "ix2 kept", ix2_o, 0);
   endtask

   task automatic t_halt();
      issue(16'h7001, 0, 0, "R9");
      chk("R9", "halted", halted_o, 1);
      chk("R9", "ready low", instr_ready, 0);
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = 16'h7200;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R9", "no exec", exec_done_o, 0);
      end
      instr_valid = 1'b0;
      chk("R9", "acc kept", acc_o, 2);
      chk("R9", "pc kept", pc_o, m_pc);
      chk("R9", "still halted", halted_o, 1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_pc = 0;
      t_reset_state();
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst_n       = 1'b0;
      instr_valid = 1'b0;
      instr_word  = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_clear_cpl();
      t_rotate();
      t_increment();
      t_skips();
      t_swaps();
      t_index_skip();
      t_illegal();
      t_other_class();
      t_halt();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule